// File: doc/BRIEF.md
# Privileged Register Access Trap Arbiter

This block decides the outcome of a software read or write aimed at a privileged control register. Each request carries the privilege level it comes from (0 to 3). It also carries the state of the machine around that level: whether 32-bit support exists at level 1, whether levels 2 and 3 are enabled or present, whether each of them runs in 64-bit or 32-bit mode, a set of trap-enable bits, and two debug qualifiers. The block returns one action code and a syndrome class. The exception itself is taken elsewhere.

The trap sources are resolved by a fixed priority chain. The chain used depends on the requesting level, and the form of a level-2 trap depends on the mode of level 2. Reads and writes go through the same decision. By default the answer is registered, so it appears one cycle after the request, qualified by a valid strobe that lasts one cycle. Setting `REG_OUT` to 0 makes the answer combinational and returns it in the same cycle.

Top module: `sysreg_trap_arbiter`

## Requirements
- R1: When `hasNarrowL1` is 0, every request gets action 1 (undefined), whatever its level.
- R2: A request from level 0 gets action 1 (undefined).
- R3: A request from level 3 gets action 0 (allow) when `hasNarrowL1` is 1.
- R4: At levels 1 and 2, when `dbgUndefPrio` is 1 and the level-3 gate holds, the action is 1. The gate is `lvl3Present`, `lvl3Wide` and `l3AccessTrap` all at 1. This result overrides every level-2 trap.
- R5: At level 1, when `lvl2Enabled` is 1 and either `l2CoprocTrap` or `l2AccessTrap` is set, the level-2 trap wins over the level-3 gate. When none of the trap sources fires, the action is 0.
- R6: A level-2 trap gives action 2 when `lvl2Wide` is 1 and action 3 (32-bit hypervisor style) when `lvl2Wide` is 0. When `lvl2Enabled` is 0, the level-2 trap bits have no effect.
- R7: When the level-3 gate holds and R4 does not apply, the action is 4 (trap to level 3) if `dbgUndefActive` is 0, or 1 if `dbgUndefActive` is 1. The gate stays closed when level 3 is absent or runs in 32-bit mode.
- R8: At level 2, the level-2 trap bits have no effect, and only the level-3 checks of R4 and R7 apply.
- R9: `rspSyndrome` is 0x03 with actions 2, 3 and 4, and 0 otherwise.
- R10: With `REG_OUT`=1, `rspValid` is high exactly in the cycle after a cycle with `reqValid` high. While `rspValid` is low, action and syndrome are 0.
- R11: During reset, `rspValid`, `rspAction` and `rspSyndrome` are 0.
- R12: `rspWrite` returns the request's `reqWrite` alongside the answer, and the action does not depend on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request strobe |
| reqWrite | input | 1 | 1 for write, 0 for read |
| curLevel | input | 2 | Requesting privilege level |
| hasNarrowL1 | input | 1 | 32-bit support at level 1 present |
| lvl2Enabled | input | 1 | Level 2 enabled |
| lvl2Wide | input | 1 | Level 2 runs 64-bit |
| lvl3Present | input | 1 | Level 3 implemented |
| lvl3Wide | input | 1 | Level 3 runs 64-bit |
| l2CoprocTrap | input | 1 | Level-2 coprocessor register trap enable |
| l2AccessTrap | input | 1 | Level-2 control access trap enable |
| l3AccessTrap | input | 1 | Level-3 control access trap enable |
| dbgUndefPrio | input | 1 | Debug qualifier: level-3 undefined takes top priority |
| dbgUndefActive | input | 1 | Debug qualifier: level-3 trap becomes undefined |
| rspValid | output | 1 | Answer valid strobe |
| rspWrite | output | 1 | Echo of reqWrite |
| rspAction | output | 3 | 0 allow, 1 undefined, 2 level-2 64-bit trap, 3 level-2 hypervisor trap, 4 level-3 trap |
| rspSyndrome | output | SYN_W | Syndrome class, 0x03 on traps |

## Verification
Every answer is due in the cycle after its request, because it passes through the single output register. The bench computes each expected answer when it drives the request and places it in a queue. At the next falling edge it takes that entry out and compares it with the outputs, so every comparison is made against the request that produced the answer. Cycles without a request queue an idle expectation, which checks that the strobe and the answer fields fall back to zero. The reset state is checked at falling edges while reset is held.

// File: rtl/sysreg_trap_pkg.sv
package sysreg_trap_pkg;

  typedef enum logic [2:0] {
    ACT_ALLOW       = 3'd0,
    ACT_UNDEF       = 3'd1,
    ACT_TRAP_L2_W64 = 3'd2,
    ACT_TRAP_L2_HYP = 3'd3,
    ACT_TRAP_L3     = 3'd4
  } action_e;

  // Strobes from the priority chain to the encoder; at most one is set.
  typedef struct packed {
    logic undef;
    logic trapL2;
    logic trapL3;
  } verdict_t;

  localparam int TRAP_CLASS = 3;

endpackage

// File: rtl/sysreg_trap_ctrl.sv
module sysreg_trap_ctrl
  import sysreg_trap_pkg::*;
(
  input  logic [1:0] curLevel,
  input  logic       hasNarrowL1,
  input  logic       lvl2Enabled,
  input  logic       lvl3Present,
  input  logic       lvl3Wide,
  input  logic       l2CoprocTrap,
  input  logic       l2AccessTrap,
  input  logic       l3AccessTrap,
  input  logic       dbgUndefPrio,
  input  logic       dbgUndefActive,
  output verdict_t   verdict
);

  logic l3Gate;
  logic l3Early;
  logic l2Hit;

  assign l3Gate  = lvl3Present && lvl3Wide && l3AccessTrap;
  assign l3Early = dbgUndefPrio && l3Gate;
  assign l2Hit   = lvl2Enabled && (l2CoprocTrap || l2AccessTrap);

  always_comb begin
    verdict = '0;
    if (!hasNarrowL1) begin
      verdict.undef = 1'b1;
    end else begin
      unique case (curLevel)
        2'd0: verdict.undef = 1'b1;
        2'd1: begin
          if (l3Early)     verdict.undef  = 1'b1;
          else if (l2Hit)  verdict.trapL2 = 1'b1;
          else if (l3Gate) begin
            if (dbgUndefActive) verdict.undef  = 1'b1;
            else                verdict.trapL3 = 1'b1;
          end
        end
        2'd2: begin
          if (l3Early) verdict.undef = 1'b1;
          else if (l3Gate) begin
            if (dbgUndefActive) verdict.undef  = 1'b1;
            else                verdict.trapL3 = 1'b1;
          end
        end
        default: verdict = '0;
      endcase
    end
  end

endmodule

// File: rtl/sysreg_trap_dpath.sv
module sysreg_trap_dpath
  import sysreg_trap_pkg::*;
#(
  parameter bit REG_OUT = 1'b1,
  parameter int SYN_W   = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic             lvl2Wide,
  input  verdict_t         verdict,
  output logic             rspValid,
  output logic             rspWrite,
  output logic [2:0]       rspAction,
  output logic [SYN_W-1:0] rspSyndrome
);

  localparam logic [SYN_W-1:0] SYN_TRAP = SYN_W'(TRAP_CLASS);

  action_e          nextAct;
  logic [SYN_W-1:0] nextSyn;

  always_comb begin
    nextAct = ACT_ALLOW;
    if (reqValid) begin
      if (verdict.undef)       nextAct = ACT_UNDEF;
      else if (verdict.trapL2) nextAct = lvl2Wide ? ACT_TRAP_L2_W64 : ACT_TRAP_L2_HYP;
      else if (verdict.trapL3) nextAct = ACT_TRAP_L3;
    end
    nextSyn = (reqValid && (verdict.trapL2 || verdict.trapL3) && !verdict.undef)
              ? SYN_TRAP : '0;
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          rspValid    <= 1'b0;
          rspWrite    <= 1'b0;
          rspAction   <= ACT_ALLOW;
          rspSyndrome <= '0;
        end else begin
          rspValid    <= reqValid;
          rspWrite    <= reqValid && reqWrite;
          rspAction   <= nextAct;
          rspSyndrome <= nextSyn;
        end
      end
    end else begin : g_comb
      assign rspValid    = reqValid;
      assign rspWrite    = reqValid && reqWrite;
      assign rspAction   = nextAct;
      assign rspSyndrome = nextSyn;
    end
  endgenerate

  AST_VERDICT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(verdict)); // R4
  AST_TRAP_SYNDROME: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && (rspAction >= 3'd2) |-> rspSyndrome == SYN_TRAP); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (rspAction == 3'd0) && (rspSyndrome == '0)); // R10

endmodule

// File: rtl/sysreg_trap_arbiter.sv
module sysreg_trap_arbiter
  import sysreg_trap_pkg::*;
#(
  parameter bit REG_OUT = 1'b1,
  parameter int SYN_W   = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [1:0]       curLevel,
  input  logic             hasNarrowL1,
  input  logic             lvl2Enabled,
  input  logic             lvl2Wide,
  input  logic             lvl3Present,
  input  logic             lvl3Wide,
  input  logic             l2CoprocTrap,
  input  logic             l2AccessTrap,
  input  logic             l3AccessTrap,
  input  logic             dbgUndefPrio,
  input  logic             dbgUndefActive,
  output logic             rspValid,
  output logic             rspWrite,
  output logic [2:0]       rspAction,
  output logic [SYN_W-1:0] rspSyndrome
);

  verdict_t verdict;

  sysreg_trap_ctrl u_ctrl (
    .curLevel       (curLevel),
    .hasNarrowL1    (hasNarrowL1),
    .lvl2Enabled    (lvl2Enabled),
    .lvl3Present    (lvl3Present),
    .lvl3Wide       (lvl3Wide),
    .l2CoprocTrap   (l2CoprocTrap),
    .l2AccessTrap   (l2AccessTrap),
    .l3AccessTrap   (l3AccessTrap),
    .dbgUndefPrio   (dbgUndefPrio),
    .dbgUndefActive (dbgUndefActive),
    .verdict        (verdict)
  );

  sysreg_trap_dpath #(.REG_OUT(REG_OUT), .SYN_W(SYN_W)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqWrite    (reqWrite),
    .lvl2Wide    (lvl2Wide),
    .verdict     (verdict),
    .rspValid    (rspValid),
    .rspWrite    (rspWrite),
    .rspAction   (rspAction),
    .rspSyndrome (rspSyndrome)
  );

  generate
    if (REG_OUT) begin : g_chk
      AST_NO_NARROW_UNDEF: assert property (@(posedge clk) disable iff (!rstN)
        reqValid && !hasNarrowL1 |=> rspAction == 3'd1); // R1
      AST_LVL0_UNDEF: assert property (@(posedge clk) disable iff (!rstN)
        reqValid && curLevel == 2'd0 |=> rspAction == 3'd1); // R2
      AST_LVL3_ALLOW: assert property (@(posedge clk) disable iff (!rstN)
        reqValid && hasNarrowL1 && curLevel == 2'd3 |=> rspAction == 3'd0); // R3
      AST_LVL2_NO_L2TRAP: assert property (@(posedge clk) disable iff (!rstN)
        reqValid && curLevel == 2'd2 |=> rspAction != 3'd2 && rspAction != 3'd3); // R8
      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
        reqValid |=> rspValid); // R10
      AST_VALID_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
        !reqValid |=> !rspValid); // R10
    end
  endgenerate

endmodule

// File: tb/sysreg_trap_arbiter_bench.sv
`timescale 1ns/1ps
module sysreg_trap_arbiter_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0] curLevel = 2'd0;
  logic       hasNarrowL1 = 1'b1, lvl2Enabled = 1'b0, lvl2Wide = 1'b0;
  logic       lvl3Present = 1'b0, lvl3Wide = 1'b0;
  logic       l2CoprocTrap = 1'b0, l2AccessTrap = 1'b0, l3AccessTrap = 1'b0;
  logic       dbgUndefPrio = 1'b0, dbgUndefActive = 1'b0;
  logic       rspValid, rspWrite;
  logic [2:0] rspAction;
  logic [5:0] rspSyndrome;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit    valid;
    bit    write;
    int    act;
    int    syn;
    string tag;
  } exp_t;

  exp_t expQ[$];

  always #2.5 clk = ~clk;

  sysreg_trap_arbiter u_sysreg_trap_arbiter (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .curLevel(curLevel), .hasNarrowL1(hasNarrowL1), .lvl2Enabled(lvl2Enabled),
    .lvl2Wide(lvl2Wide), .lvl3Present(lvl3Present), .lvl3Wide(lvl3Wide),
    .l2CoprocTrap(l2CoprocTrap), .l2AccessTrap(l2AccessTrap),
    .l3AccessTrap(l3AccessTrap), .dbgUndefPrio(dbgUndefPrio),
    .dbgUndefActive(dbgUndefActive), .rspValid(rspValid), .rspWrite(rspWrite),
    .rspAction(rspAction), .rspSyndrome(rspSyndrome)
  );

  // Behavioural reference drawn from the requirements.
  function automatic int refAction(output string tag);
    bit gate3;
    gate3 = lvl3Present && lvl3Wide && l3AccessTrap;
    if (!hasNarrowL1)   begin tag = "R1"; return 1; end
    if (curLevel == 0)  begin tag = "R2"; return 1; end
    if (curLevel == 3)  begin tag = "R3"; return 0; end
    if (dbgUndefPrio && gate3) begin tag = "R4"; return 1; end
    if (curLevel == 1 && lvl2Enabled && (l2CoprocTrap || l2AccessTrap)) begin
      tag = gate3 ? "R5" : "R6";
      return lvl2Wide ? 2 : 3;
    end
    if (gate3) begin tag = "R7"; return dbgUndefActive ? 1 : 4; end
    tag = (curLevel == 2) ? "R8" : "R5";
    return 0;
  endfunction

  function automatic exp_t makeExp();
    exp_t e;
    string t;
    e.valid = reqValid;
    e.write = reqValid && reqWrite;
    if (reqValid) begin
      e.act = refAction(t);
      e.tag = t;
    end else begin
      e.act = 0;
      e.tag = "R10";
    end
    e.syn = (e.act >= 2) ? 3 : 0;
    return e;
  endfunction

  task automatic checkOne(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic compareNow();
    exp_t e;
    if (expQ.size() == 0) return;
    e = expQ.pop_front();
    checkOne("R10", int'(rspValid), int'(e.valid));
    checkOne("R12", int'(rspWrite), int'(e.write));
    checkOne(e.tag, int'(rspAction), e.act);
    checkOne("R9", int'(rspSyndrome), e.syn);
  endtask

  // One cycle: check the answer due now, then drive the next request.
  task automatic step(bit v, bit w, int lvl, bit nar, bit l2e, bit l2w, bit l3p,
                      bit l3w, bit cpT, bit a2, bit a3, bit dp, bit du);
    @(negedge clk);
    compareNow();
    reqValid = v; reqWrite = w; curLevel = 2'(lvl); hasNarrowL1 = nar;
    lvl2Enabled = l2e; lvl2Wide = l2w; lvl3Present = l3p; lvl3Wide = l3w;
    l2CoprocTrap = cpT; l2AccessTrap = a2; l3AccessTrap = a3;
    dbgUndefPrio = dp; dbgUndefActive = du;
    expQ.push_back(makeExp());
  endtask

  initial begin
    // Reset state, with a request pending on the inputs (R11)
    reqValid = 1'b1;
    curLevel = 2'd0;
    repeat (3) begin
      @(negedge clk);
      checkOne("R11", int'(rspValid), 0);
      checkOne("R11", int'(rspAction), 0);
      checkOne("R11", int'(rspSyndrome), 0);
    end
    reqValid = 1'b0;
    rstN = 1'b1;
    expQ.push_back(makeExp());

    //    v w lvl nar l2e l2w l3p l3w cp a2 a3 dp du
    step(1,0, 2, 0, 0,  0,  0,  0,  0, 0, 0, 0, 0); // R1 level 2
    step(1,1, 3, 0, 0,  0,  0,  0,  0, 0, 0, 0, 0); // R1 level 3
    step(1,0, 0, 1, 1,  1,  1,  1,  1, 1, 1, 1, 1); // R2
    step(1,1, 3, 1, 1,  1,  1,  1,  1, 1, 1, 1, 1); // R3
    step(1,0, 1, 1, 1,  1,  1,  1,  1, 1, 1, 1, 0); // R4 beats level-2 trap
    step(1,0, 1, 1, 1,  1,  1,  1,  1, 0, 1, 0, 0); // R5 level 2 beats level 3
    step(1,1, 1, 1, 1,  0,  1,  1,  0, 1, 1, 0, 1); // R5 hyp style
    step(1,0, 1, 1, 1,  1,  0,  0,  0, 0, 0, 0, 0); // R5 allow
    step(1,0, 1, 1, 1,  1,  0,  0,  1, 0, 0, 0, 0); // R6 wide
    step(1,0, 1, 1, 1,  0,  0,  0,  0, 1, 0, 0, 0); // R6 hyp
    step(1,0, 1, 1, 0,  1,  0,  0,  1, 1, 0, 0, 0); // R6 level 2 disabled
    step(1,0, 1, 1, 0,  0,  1,  1,  0, 0, 1, 0, 0); // R7 trap to 3
    step(1,1, 1, 1, 0,  0,  1,  1,  0, 0, 1, 0, 1); // R7 debug undefined
    step(1,0, 1, 1, 0,  0,  1,  0,  0, 0, 1, 1, 0); // R7 level 3 narrow
    step(1,0, 1, 1, 0,  0,  0,  1,  0, 0, 1, 1, 0); // R7 level 3 absent
    step(1,0, 2, 1, 1,  1,  0,  0,  1, 1, 0, 0, 0); // R8 ignores l2 bits
    step(1,0, 2, 1, 1,  0,  1,  1,  1, 1, 1, 0, 0); // R8 level-3 trap
    step(1,1, 2, 1, 1,  1,  1,  1,  0, 0, 1, 1, 0); // R8 early undef
    step(0,1, 1, 1, 1,  1,  1,  1,  1, 1, 1, 0, 0); // R10 no request
    step(1,1, 1, 1, 1,  1,  0,  0,  1, 0, 0, 0, 0); // R12 write
    step(1,0, 1, 1, 1,  1,  0,  0,  1, 0, 0, 0, 0); // R12 read

    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 3) != 0, 1'($urandom), $urandom_range(0, 3),
           $urandom_range(0, 7) != 0, 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom));
    end
    step(0,0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compareNow();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule